// File: doc/BRIEF.md
# Paired Set/Clear GPIO Control Register

This block is a 32-bit control register for up to eight general-purpose pins. Software never writes a pin's level or direction as a plain value. Each pin owns two bit pairs instead, and a 1 in one bit of a pair is a command.

- **Level pair.** For local pin n, the pair sits in the lower half at bits 2n and 2n+1. Bit 2n drives the pin low and bit 2n+1 drives it high.
- **Direction pair.** The pair sits in the upper half at bits 16+2n and 17+2n. Bit 16+2n makes the pin an output and bit 17+2n makes it an input.

A pin whose pairs carry no single asserted bit keeps its state. Software can therefore change one pin with a single write and no read-modify-write, even when other agents share the register.

Readback is combinational, and its meaning depends on each pin's direction. An output pin reads its enable position as 1 and its driven level in the low-level position. An input pin reads its synchronized pad value in the high-level position. A level toggle uses the same encoding: read the low-level position, then write the low command if it was 1 and the high command otherwise. Two instances, one with eight pins and one with four, cover a twelve-pin extension bank.

Top module: `gpio_pair_reg`

## Requirements
- R1: While rst_ni is low and after its release, every pin is an input (pin_oe_o = 0) with stored level 0 (pin_out_o = 0), and rd_data_o reads 0 while pin_i is low.
- R2: A write whose level pair for pin n is 01 (bit 2n = 1, bit 2n+1 = 0) makes pin_out_o[n] 0 after the clock edge. A pair of 10 makes it 1.
- R3: A level pair of 11 or 00 leaves pin_out_o[n] unchanged, and so does any cycle without wr_en_i.
- R4: A direction pair of 01 (bit 16+2n = 1) makes pin_oe_o[n] 1 and a pair of 10 (bit 17+2n = 1) makes it 0. A pair of 11 or 00 leaves it unchanged.
- R5: A write changes only the pins whose pairs carry exactly one asserted bit. All other pins keep level and direction.
- R6: For an output pin n, rd_data_o reads bit 16+2n = 1, bit 17+2n = 0, bit 2n = driven level and bit 2n+1 = 0.
- R7: For an input pin n, rd_data_o reads bits 2n, 16+2n and 17+2n as 0. Bit 2n+1 shows pin_i[n] through a two-flop synchronizer, so a change at pin_i appears after the second rising clock edge.
- R8: With NUM_PINS below 8, the pair bits of local pins at or above NUM_PINS read as 0, and writes to them have no effect.
- R9: Reading bit 2n of an output pin and then writing the low command if it was 1, or the high command if it was 0, inverts pin_out_o[n].
- R10: The stored level is kept across direction changes, and it can be written while the pin is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for wr_data_i |
| wr_data_i | input | 32 | Paired command word: level pairs in 15:0, direction pairs in 31:16 |
| rd_data_o | output | 32 | Combinational readback word |
| pin_i | input | NUM_PINS | Pad input values, asynchronous |
| pin_oe_o | output | NUM_PINS | Output enable per pin |
| pin_out_o | output | NUM_PINS | Driven level per pin |

## Verification
A wrong level or direction state shows at pin_out_o or pin_oe_o on the first clock edge after the write that caused it. It shows in rd_data_o at once, because readback has no register stage. A missing or extra synchronizer stage shifts the input readback by one edge, so input values are sampled after exactly one edge and again after two. A command that leaks into a neighbouring pin, or a both-bits pair that is not ignored, changes an output bit that is expected to hold. The vector walk checks every pin after every write.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned HALF_W   = REG_W / 2;
  localparam int unsigned MAX_PINS = HALF_W / 2;

  // Pair command: lower bit alone, upper bit alone, or no action.
  typedef enum logic [1:0] {
    PAIR_NONE  = 2'd0,
    PAIR_LOWER = 2'd1,
    PAIR_UPPER = 2'd2
  } pair_cmd_e;

  function automatic pair_cmd_e decode_pair(input logic [1:0] bits);
    case (bits)
      2'b01:   return PAIR_LOWER;
      2'b10:   return PAIR_UPPER;
      default: return PAIR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_pair_cell.sv
module gpio_pair_cell
  import gpio_pair_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] lvl_pair_i,  // [0] drive low, [1] drive high
  input  logic [1:0] dir_pair_i,  // [0] output, [1] input
  output logic       oe_o,
  output logic       lvl_o
);
  logic oe_q, lvl_q;
  pair_cmd_e lvl_cmd, dir_cmd;

  assign lvl_cmd = decode_pair(lvl_pair_i);
  assign dir_cmd = decode_pair(dir_pair_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else if (wr_en_i) begin
      case (lvl_cmd)
        PAIR_LOWER: lvl_q <= 1'b0;
        PAIR_UPPER: lvl_q <= 1'b1;
        default:    lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q <= 1'b0;
    end else if (wr_en_i) begin
      case (dir_cmd)
        PAIR_LOWER: oe_q <= 1'b1;
        PAIR_UPPER: oe_q <= 1'b0;
        default:    oe_q <= oe_q;
      endcase
    end
  end

  assign oe_o  = oe_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/gpio_pair_readback.sv
module gpio_pair_readback
  import gpio_pair_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] oe_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] pad_sync_i,
  output logic [REG_W-1:0]    rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    for (int n = 0; n < int'(NUM_PINS); n++) begin
      rd_data_o[2*n]            = oe_i[n] & lvl_i[n];
      rd_data_o[2*n+1]          = ~oe_i[n] & pad_sync_i[n];
      rd_data_o[HALF_W + 2*n]   = oe_i[n];
      rd_data_o[HALF_W + 2*n+1] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pair_reg.sv
module gpio_pair_reg
  import gpio_pair_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_out_o
);
  localparam int unsigned DIR_BASE = HALF_W;

  logic [NUM_PINS-1:0] pad_sync;

  gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pad_sync)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gpio_pair_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .lvl_pair_i (wr_data_i[2*n+1 : 2*n]),
      .dir_pair_i (wr_data_i[DIR_BASE+2*n+1 : DIR_BASE+2*n]),
      .oe_o       (pin_oe_o[n]),
      .lvl_o      (pin_out_o[n])
    );
  end

  gpio_pair_readback #(.NUM_PINS(NUM_PINS)) u_rb (
    .oe_i       (pin_oe_o),
    .lvl_i      (pin_out_o),
    .pad_sync_i (pad_sync),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/gpio_pair_reg_chk.sv
module gpio_pair_reg_chk
  import gpio_pair_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [REG_W-1:0]    wr_data_i,
  input logic [REG_W-1:0]    rd_data_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [NUM_PINS-1:0] pin_out_o
);
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    // R2
    lvl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_data_i[2*n] && !wr_data_i[2*n+1] |=> !pin_out_o[n]);
    // R2
    lvl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !wr_data_i[2*n] && wr_data_i[2*n+1] |=> pin_out_o[n]);
    // R3
    lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && (wr_data_i[2*n] ^ wr_data_i[2*n+1])) |=> $stable(pin_out_o[n]));
    // R4
    oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_data_i[HALF_W+2*n] && !wr_data_i[HALF_W+2*n+1] |=> pin_oe_o[n]);
    // R4
    oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !wr_data_i[HALF_W+2*n] && wr_data_i[HALF_W+2*n+1] |=> !pin_oe_o[n]);
    // R4
    oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && (wr_data_i[HALF_W+2*n] ^ wr_data_i[HALF_W+2*n+1])) |=> $stable(pin_oe_o[n]));
    // R6
    rd_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_oe_o[n] |-> rd_data_o[HALF_W+2*n] && !rd_data_o[HALF_W+2*n+1]
                      && !rd_data_o[2*n+1] && (rd_data_o[2*n] == pin_out_o[n]));
    // R7
    rd_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_oe_o[n] |-> !rd_data_o[HALF_W+2*n] && !rd_data_o[HALF_W+2*n+1] && !rd_data_o[2*n]);
  end

  if (NUM_PINS < MAX_PINS) begin : g_unused
    // R8
    rd_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[HALF_W-1 : 2*NUM_PINS] == '0 && rd_data_o[REG_W-1 : HALF_W+2*NUM_PINS] == '0);
  end
endmodule

bind gpio_pair_reg gpio_pair_reg_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .pin_oe_o  (pin_oe_o),
  .pin_out_o (pin_out_o)
);

// File: tb/gpio_pair_reg_test.sv
module gpio_pair_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {write word, expected oe, expected level}
  localparam logic [47:0] VEC [NVEC] = '{
    48'h0000AAAA_00_FF,
    48'h00000001_00_FE,
    48'h55550000_FF_FE,
    48'h00000003_FF_FE,
    48'h00000000_FF_FE,
    48'h00080004_FD_FC,
    48'hFFFFFFFF_FD_FC,
    48'h00004000_FD_7C,
    48'hA0000000_3D_7C,
    48'h00030002_3D_7D
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0] pin8 = '0;
  logic [3:0] pin4 = '0;
  logic [31:0] rd8, rd4;
  logic [7:0] oe8, out8;
  logic [3:0] oe4, out4;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pair_reg #(.NUM_PINS(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd8), .pin_i(pin8), .pin_oe_o(oe8), .pin_out_o(out8));

  gpio_pair_reg #(.NUM_PINS(4)) uut4 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd4), .pin_i(pin4), .pin_oe_o(oe4), .pin_out_o(out4));

  function automatic logic [31:0] exp_rd(input logic [7:0] oe, input logic [7:0] lvl,
                                         input logic [7:0] pad);
    logic [31:0] r = '0;
    for (int n = 0; n < 8; n++) begin
      if (oe[n]) begin
        r[16+2*n] = 1'b1;
        r[2*n]    = lvl[n];
      end else begin
        r[2*n+1]  = pad[n];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic toggle_pin(input int p);
    logic [31:0] cmd = '0;
    @(negedge clk);
    if (rd8[2*p]) cmd[2*p] = 1'b1;
    else cmd[2*p+1] = 1'b1;
    do_write(cmd);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic prev;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", {24'd0, oe8}, 32'd0);
    check("R1 level in reset", {24'd0, out8}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 readback after reset", rd8, 32'd0);
    check("R1 oe after reset", {24'd0, oe8}, 32'd0);

    // vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][47:16]);
      check("R2/R3/R5 level vector", {24'd0, out8}, {24'd0, VEC[i][7:0]});
      check("R4/R5 oe vector", {24'd0, oe8}, {24'd0, VEC[i][15:8]});
      check("R6 readback vector", rd8, exp_rd(VEC[i][15:8], VEC[i][7:0], 8'h00));
    end

    // R7: all inputs, synchronizer latency
    do_write(32'hAAAA_0000);
    repeat (3) @(negedge clk);
    pin8 = 8'h5A;
    @(negedge clk);
    check("R7 one edge after pad change", rd8, 32'd0);
    @(negedge clk);
    check("R7 two edges after pad change", rd8, exp_rd(8'h00, 8'h00, 8'h5A));
    pin8 = 8'h00;
    repeat (3) @(negedge clk);
    check("R7 pad returns low", rd8, 32'd0);

    // R10: level written while input, kept across direction change
    do_write(32'h0000_0080);  // pin3 high while input
    check("R10 level written in input mode", {31'd0, out8[3]}, 32'd1);
    check("R10 input pin readback ignores level", rd8, 32'd0);
    do_write(32'h0040_0000);  // pin3 output
    check("R10 level kept on enable", rd8, exp_rd(8'h08, out8, 8'h00));
    do_write(32'h0080_0000);  // pin3 input
    do_write(32'h0040_0000);
    check("R10 level kept across input phase", {31'd0, out8[3]}, 32'd1);

    // R9: toggle by read then write
    prev = out8[3];
    toggle_pin(3);
    check("R9 toggle one", {31'd0, out8[3]}, {31'd0, ~prev});
    toggle_pin(3);
    check("R9 toggle two", {31'd0, out8[3]}, {31'd0, prev});

    // R8: four-pin instance
    do_write(32'h5555_AAAA);
    check("R8 narrow readback", rd4, 32'h0055_0055);
    check("R8 narrow oe", {28'd0, oe4}, 32'h0000_000F);
    do_write(32'h5500_AA00);
    check("R8 out-of-range write ignored", rd4, 32'h0055_0055);
    check("R8 out-of-range level unchanged", {28'd0, out4}, 32'h0000_000F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule